// File: doc/BRIEF.md
# Serial Signature Analysis Register

This block compresses a serial bit stream into a 16-bit signature. The stream is taken from a circuit node, one bit per accepted transfer. The bits go through a feedback shift register built on the fixed primitive polynomial x^16 + x^9 + x^7 + x^4 + 1. A restart clears the register and latches the window length and the operating mode. Each accepted bit advances the register by one position. When the programmed number of bits has been taken, the signature freezes, the done flag rises, and the input stops accepting data until the next restart.

The frozen signature is also shown as four ASCII characters. Each character stands for one nibble and is drawn from the sixteen-symbol alphabet 0-9, A, C, F, H, P, U. In the stimulus mode, the serial input is replaced by zero and the register is seeded with 0x0001. The register then steps through a maximal-length sequence of 65535 states, and the bit that leaves the register on each step is available as a pseudo-random stimulus bit.

The serial input uses a valid/ready handshake. A bit is consumed on a rising clock edge where `in_valid` and `in_ready` are both high and `restart` is low. `in_ready` is high exactly while the window is still open. A source may hold `in_valid` low for any number of cycles without changing the result, and must hold `in_bit` stable until the transfer completes.

Top module: `sig_analyzer`

## Requirements
- R1: After reset, `signature` is 0, `done` is low, `in_ready` is high, the latched window length is 16 and the stimulus mode is off.
- R2: A cycle with `restart` high loads the register on the next edge. It loads 0 when `prbs_mode` is low and 0x0001 when `prbs_mode` is high. The same edge latches `win_len` and `prbs_mode`. A handshake in that same cycle is not consumed.
- R3: Each consumed bit shifts the register one place toward bit 0. The new bit 15 is V = in_bit XOR s[12] XOR s[9] XOR s[7] XOR s[0]. Bit 15 is the input-side position 1 and bit 0 is position 16, so the taps are positions 4, 7, 9 and 16. The old bit 0 is discarded.
- R4: In a cycle without a completed handshake and without restart, the signature does not change. Gaps in `in_valid` therefore leave the final signature unchanged.
- R5: `done` rises on the edge that consumes the bit that brings the count of consumed bits to the latched length. A latched length of 0 makes `done` high right after restart. `in_ready` equals NOT `done`.
- R6: While `done` is high, `in_valid` pulses are ignored and the signature is held until the next restart.
- R7: `disp_chars[31:24]` encodes `signature[15:12]` and `disp_chars[7:0]` encodes `signature[3:0]`. Nibble values 0..9 map to ASCII '0'..'9', and 10..15 map to 'A','C','F','H','P','U'.
- R8: In stimulus mode, `in_bit` is treated as 0. `prbs_bit` equals `signature[0]`, which is the bit that the next step discards. Starting from seed 0x0001, the register returns to 0x0001 after exactly 65535 steps and not before.
- R9: An all-zero stream leaves a zero signature. Flipping any single bit of a 16-bit stream changes the signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Start a new measurement window |
| prbs_mode | input | 1 | Stimulus mode select, latched at restart |
| win_len | input | 16 | Window length in bits, latched at restart |
| in_valid | input | 1 | Serial bit offered |
| in_ready | output | 1 | Window open, bit will be taken |
| in_bit | input | 1 | Serial data bit from the probed node |
| done | output | 1 | Window complete, signature frozen |
| signature | output | 16 | Current register contents |
| disp_chars | output | 32 | Four ASCII characters, most significant nibble first |
| prbs_bit | output | 1 | Bit discarded on the next step |

## Verification
The bench builds the block with its default parameters: a 16-bit register and a 16-bit window counter.

The 16-bit width puts the full maximal-length cycle within reach. The bench runs all 65535 stimulus steps and follows the output bit on every step against an arithmetic model.

Over 16-bit windows it sweeps 256 structured patterns and flips every single bit of one base pattern. It also covers a zero stream, a zero-length window, handshake gaps, steps after done, and a step that coincides with restart. In each case the signature and its displayed characters are compared with values the bench computes itself.

// File: rtl/sig_pkg.sv
package sig_pkg;
  localparam int SIG_W    = 16;
  localparam int NIB_N    = SIG_W / 4;
  // feedback taps: bits 12, 9, 7, 0  (positions 4, 7, 9, 16)
  localparam logic [SIG_W-1:0] TAP_MASK = 16'h1281;
  localparam logic [SIG_W-1:0] PRBS_SEED = 16'h0001;

  function automatic logic [7:0] glyph(input logic [3:0] v);
    logic [7:0] g;
    case (v)
      4'd10:   g = 8'h41; // A
      4'd11:   g = 8'h43; // C
      4'd12:   g = 8'h46; // F
      4'd13:   g = 8'h48; // H
      4'd14:   g = 8'h50; // P
      4'd15:   g = 8'h55; // U
      default: g = 8'h30 + {4'd0, v};
    endcase
    return g;
  endfunction
endpackage

// File: rtl/sig_lfsr.sv
module sig_lfsr #(
  parameter int W = 16,
  parameter logic [W-1:0] TAPS = 16'h1281
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         din,
  output logic [W-1:0] state
);
  logic fb;

  always_comb fb = din ^ (^(state & TAPS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= '0;
    else if (load) state <= load_val;
    else if (step) state <= {fb, state[W-1:1]};
  end
endmodule

// File: rtl/sig_window.sv
module sig_window #(
  parameter int LEN_W = 16,
  parameter int DEF_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [LEN_W-1:0] len_in,
  input  logic             step,
  output logic             done
);
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= LEN_W'(DEF_LEN);
      cnt_q <= '0;
    end else if (restart) begin
      len_q <= len_in;
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb done = (cnt_q == len_q);
endmodule

// File: rtl/sig_display.sv
module sig_display #(
  parameter int W = 16
) (
  input  logic [W-1:0]   value,
  output logic [2*W-1:0] chars
);
  localparam int N = W / 4;

  for (genvar i = 0; i < N; i++) begin : g_nib
    always_comb chars[8*i +: 8] = sig_pkg::glyph(value[4*i +: 4]);
  end
endmodule

// File: rtl/sig_analyzer.sv
module sig_analyzer #(
  parameter int LEN_W   = 16,
  parameter int DEF_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             prbs_mode,
  input  logic [LEN_W-1:0] win_len,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  output logic             done,
  output logic [15:0]      signature,
  output logic [31:0]      disp_chars,
  output logic             prbs_bit
);
  import sig_pkg::*;

  logic prbs_q;
  logic step;
  logic din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prbs_q <= 1'b0;
    else if (restart) prbs_q <= prbs_mode;
  end

  always_comb begin
    in_ready = ~done;
    step     = in_valid & in_ready & ~restart;
    din      = prbs_q ? 1'b0 : in_bit;
    prbs_bit = signature[0];
  end

  sig_window #(.LEN_W(LEN_W), .DEF_LEN(DEF_LEN)) i_window (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .len_in(win_len), .step(step), .done(done)
  );

  sig_lfsr #(.W(SIG_W), .TAPS(TAP_MASK)) i_lfsr (
    .clk(clk), .rst_n(rst_n), .load(restart),
    .load_val(prbs_mode ? PRBS_SEED : '0),
    .step(step), .din(din), .state(signature)
  );

  sig_display #(.W(SIG_W)) i_disp (
    .value(signature), .chars(disp_chars)
  );
endmodule

// File: rtl/sig_analyzer_chk.sv
module sig_analyzer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        restart,
  input logic        prbs_mode,
  input logic        in_valid,
  input logic        in_ready,
  input logic        done,
  input logic [15:0] signature
);
  p_restart_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart && !prbs_mode |=> signature == 16'h0000);

  p_prbs_seed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart && prbs_mode |=> signature == 16'h0001);

  p_shift_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !restart |=> signature[14:0] == $past(signature[15:1]));

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !restart && !in_valid |=> $stable(signature));

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !restart |=> $stable(signature) && done);

  p_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready != done);
endmodule

bind sig_analyzer sig_analyzer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .prbs_mode(prbs_mode),
  .in_valid(in_valid), .in_ready(in_ready), .done(done), .signature(signature)
);

// File: tb/test_sig_analyzer.sv
module test_sig_analyzer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart = 1'b0;
  logic        prbs_mode = 1'b0;
  logic [15:0] win_len = 16'd16;
  logic        in_valid = 1'b0;
  logic        in_bit = 1'b0;
  logic        in_ready, done, prbs_bit;
  logic [15:0] signature;
  logic [31:0] disp_chars;

  int vectors = 0;
  int errors = 0;
  longint cycles = 0;
  bit finished = 0;

  localparam logic [127:0] ALPHA = "0123456789ACFHPU";

  always #5 clk = ~clk;

  sig_analyzer i_sig_analyzer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .prbs_mode(prbs_mode),
    .win_len(win_len), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .done(done), .signature(signature),
    .disp_chars(disp_chars), .prbs_bit(prbs_bit)
  );

  function automatic logic [15:0] adv(input logic [15:0] s, input logic e);
    logic v;
    v = e ^ s[12] ^ s[9] ^ s[7] ^ s[0];
    return {v, s[15:1]};
  endfunction

  function automatic logic [31:0] disp_of(input logic [15:0] s);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) begin
      int n;
      n = int'(s[4*i +: 4]);
      r[8*i +: 8] = ALPHA[8*(15-n) +: 8];
    end
    return r;
  endfunction

  function automatic logic [15:0] model_sig(input logic [15:0] pat);
    logic [15:0] s;
    s = '0;
    for (int k = 0; k < 16; k++) s = adv(s, pat[k]);
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_restart(input logic pm, input logic [15:0] len);
    @(negedge clk);
    restart = 1'b1; prbs_mode = pm; win_len = len;
    @(negedge clk);
    restart = 1'b0;
  endtask

  // feeds 16 bits LSB first; gap inserts an idle cycle before each bit
  task automatic feed(input logic [15:0] pat, input bit gap);
    for (int k = 0; k < 16; k++) begin
      if (gap) begin
        in_valid = 1'b0; in_bit = ~pat[k];
        @(negedge clk);
      end
      in_valid = 1'b1; in_bit = pat[k];
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      vectors++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [15:0] e, base_sig, prev;
    bit early;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sig", 32'(signature), 32'h0);
    chk("R1 done", 32'(done), 32'h0);
    chk("R1 ready", 32'(in_ready), 32'h1);
    chk("R7 disp reset", disp_chars, "0000");
    rst_n = 1'b1;
    @(negedge clk);
    // R1: default length 16 without restart
    feed(16'h1234, 0);
    chk("R1 default window done", 32'(done), 32'h1);
    chk("R1 default window sig", 32'(signature), 32'(model_sig(16'h1234)));

    // R9 zero stream
    do_restart(0, 16);
    chk("R2 cleared", 32'(signature), 32'h0);
    feed(16'h0000, 0);
    chk("R9 zero stream", 32'(signature), 32'h0);
    chk("R5 done", 32'(done), 32'h1);

    // R3 R7 sweep of 256 patterns
    for (int i = 0; i < 256; i++) begin
      logic [15:0] p;
      p = 16'(i * 257) ^ 16'h3C5A ^ 16'(i << 3);
      do_restart(0, 16);
      feed(p, 0);
      e = model_sig(p);
      chk("R3 sweep sig", 32'(signature), 32'(e));
      chk("R7 sweep disp", disp_chars, disp_of(e));
      chk("R5 sweep done", {30'd0, done, in_ready}, 32'h2);
      if (p != 0) chk("R9 nonzero", 32'(signature != 0), 32'h1);
    end

    // R9 single flips
    do_restart(0, 16);
    feed(16'hA5C3, 0);
    base_sig = signature;
    for (int b = 0; b < 16; b++) begin
      do_restart(0, 16);
      feed(16'hA5C3 ^ (16'h1 << b), 0);
      chk("R9 flip differs", 32'(signature != base_sig), 32'h1);
      chk("R9 flip model", 32'(signature), 32'(model_sig(16'hA5C3 ^ (16'h1 << b))));
    end

    // R4 gaps
    do_restart(0, 16);
    feed(16'hBEEF, 1);
    chk("R4 gaps", 32'(signature), 32'(model_sig(16'hBEEF)));

    // R6 steps after done ignored
    prev = signature;
    in_valid = 1'b1; in_bit = 1'b1;
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    chk("R6 hold", 32'(signature), 32'(prev));
    chk("R6 ready low", 32'(in_ready), 32'h0);

    // R5 zero length
    do_restart(0, 0);
    chk("R5 zero length done", 32'(done), 32'h1);
    in_valid = 1'b1; in_bit = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R5 zero length sig", 32'(signature), 32'h0);

    // R2 restart wins over handshake in same cycle
    do_restart(0, 16);
    in_valid = 1'b1; in_bit = 1'b1;
    @(negedge clk);                         // one bit taken
    restart = 1'b1;                         // valid still high
    @(negedge clk);
    restart = 1'b0; in_valid = 1'b0;
    chk("R2 restart priority", 32'(signature), 32'h0);
    chk("R2 restart relatch", 32'(done), 32'h0);

    // R5 short window length 3
    do_restart(0, 3);
    in_valid = 1'b1; in_bit = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R5 not yet done", 32'(done), 32'h0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R5 done at 3", 32'(done), 32'h1);
    chk("R5 sig at 3", 32'(signature), 32'(adv(adv(adv(16'h0, 1), 1), 1)));

    // R8 full PRBS period
    do_restart(1, 16'hFFFF);
    chk("R8 seed", 32'(signature), 32'h0001);
    e = 16'h0001;
    early = 0;
    in_valid = 1'b1;
    for (int k = 1; k <= 65535; k++) begin
      in_bit = k[0];
      if (prbs_bit !== e[0]) early = 1;
      @(negedge clk);
      e = adv(e, 1'b0);
      if (signature !== e) early = 1;
      if (k < 65535 && signature == 16'h0001) early = 1;
    end
    in_valid = 1'b0;
    chk("R8 stream and period", 32'(early), 32'h0);
    chk("R8 back to seed", 32'(signature), 32'h0001);
    chk("R8 done", 32'(done), 32'h1);
    chk("R7 disp seed", disp_chars, "0001");

    finish_run();
  end
endmodule